// File: doc/BRIEF.md
# Dual-Slope Converter Phase Sequencer

This block is the digital controller of a dual-slope integrating converter. It divides its input clock by four to form a count period and counts those periods in a four-digit decimal (BCD) counter. With that counter it walks the converter through three phases, in a fixed order: zeroing, input integration and reference de-integration. For each phase it drives exactly one analog switch control. During de-integration it watches the comparator that follows the integrator. The first count period in which the comparator has changed sides ends the measurement.

The signal-integration phase always lasts 1000 counts. De-integration and zeroing share a 3000-count window. Zeroing gets whatever de-integration leaves unused, but never less than 1000 counts. A full reading therefore always takes 4000 counts (16,000 input clocks), whatever the input level. The comparator side at the close of signal integration sets the sign. That sign chooses which reference polarity is switched in, so that the integrator is driven back toward zero. The number of de-integration counts is the reading. It is presented in BCD, together with the sign and an overrange flag, under a one-cycle strobe. The comparator input is asynchronous and passes through a two-flop synchroniser before any decision uses it.

Top module: `dsl_sequencer`

## Requirements
- R1: Counts advance once every 4 input clocks. The signal-integration control `sigOn` therefore stays high for exactly 4000 consecutive clocks each time it is asserted.
- R2: Phases run in the order zeroing (`azOn`), signal integration (`sigOn`), de-integration (`refDown` or `refUp`), and back to zeroing. After reset release, zeroing lasts 3000 counts, so `sigOn` is first seen high in the 12000th clock after release.
- R3: De-integration ends on the first count boundary at which the synchronised comparator differs from its value at the close of signal integration. `readingBcd` then holds the number of de-integration counts, one BCD digit per nibble, with the ones digit in bits 3:0.
- R4: A comparator value of 1 at the close of signal integration gives a positive reading (`readingNeg`=0) and asserts `refDown` during de-integration. A value of 0 gives `readingNeg`=1 and asserts `refUp`.
- R5: If the comparator has not changed after 2000 de-integration counts, the block returns to zeroing with `readingBcd` = 2000 (hex 2000) and `overRange`=1. Any reading of 1999 or less has `overRange`=0.
- R6: Successive rising edges of `sigOn` are exactly 16,000 clocks apart, whatever the reading.
- R7: `latchStrobe` is high for one clock, in the first clock of zeroing after de-integration. The new reading, sign and overrange appear in that same clock. These outputs do not change in any clock without the strobe.
- R8: Exactly one of `azOn`, `sigOn`, `refDown`, `refUp` is high in every clock.
- R9: The comparator is taken through two flops. A change first sampled at clock edge e is acted on at the first count boundary at or after edge e+2. A change that lands one clock later than that is seen one count later.
- R10: While reset is asserted, `azOn`=1, the other switch controls are 0, and `readingBcd`, `readingNeg`, `overRange` and `latchStrobe` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmpIn | input | 1 | Asynchronous comparator output, 1 when the integrator is above zero |
| azOn | output | 1 | Zeroing switch control |
| sigOn | output | 1 | Input-integration switch control |
| refDown | output | 1 | De-integrate with the reference that lowers the integrator |
| refUp | output | 1 | De-integrate with the reference that raises the integrator |
| readingBcd | output | 16 | Captured count, four BCD digits |
| readingNeg | output | 1 | Captured sign, 1 for a negative input |
| overRange | output | 1 | Captured overrange flag |
| latchStrobe | output | 1 | One-clock strobe marking a new reading |

## Verification
Every result is tied to the clock edge that starts de-integration, called t0. The bench drives a comparator flip so that it is first sampled at t0+4K-2. The reading K and its strobe are then due at edge t0+4K, because two synchroniser flops and the four-clock prescaler lie between them. A flip one clock later must move both the reading and the strobe to t0+4K+4. For overrange, the strobe is due at t0+8000. The scoreboard stores the expected edge number with each reading and compares it with a free-running edge count when the strobe appears. Phase lengths are measured in clocks: 12,000 from reset to the first signal integration, 4000 for each integration and 16,000 between starts. All outputs are sampled on the falling edge, so each comparison sees the value settled after the edge that produced it.

// File: rtl/dsl_pkg.sv
package dsl_pkg;

  typedef enum logic [1:0] {
    PH_AZ  = 2'd0,
    PH_SIG = 2'd1,
    PH_REF = 2'd2
  } phase_t;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic clrCnt;
    logic latchPol;
    logic capture;
  } seqCmd_t;

  // integer to packed BCD, up to eight digits
  function automatic logic [31:0] toBcd(input int unsigned v);
    logic [31:0] r;
    int unsigned t;
    r = '0;
    t = v;
    for (int i = 0; i < 8; i++) begin
      r[4*i +: 4] = 4'(t % 10);
      t = t / 10;
    end
    return r;
  endfunction

endpackage

// File: rtl/dsl_datapath.sv
module dsl_datapath
  import dsl_pkg::*;
#(
  parameter int DIV        = 4,
  parameter int DIGITS     = 4,
  parameter int SIG_COUNTS = 1000,
  parameter int REF_MAX    = 2000,
  parameter int AZ_MIN     = 1000
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cmpIn,
  input  seqCmd_t               cmd,
  output logic                  tick,
  output logic                  cmpSync,
  output logic                  polCmp,
  output logic                  atSigEnd,
  output logic                  atRefMax,
  output logic                  atWindowEnd,
  output logic [4*DIGITS-1:0]   readingBcd,
  output logic                  readingNeg,
  output logic                  overRange,
  output logic                  latchStrobe
);

  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int CW = 4 * DIGITS;
  localparam logic [31:0] SIG_B32 = toBcd(SIG_COUNTS);
  localparam logic [31:0] REF_B32 = toBcd(REF_MAX);
  localparam logic [31:0] WIN_B32 = toBcd(REF_MAX + AZ_MIN);
  localparam logic [CW-1:0] SIG_B = SIG_B32[CW-1:0];
  localparam logic [CW-1:0] REF_B = REF_B32[CW-1:0];
  localparam logic [CW-1:0] WIN_B = WIN_B32[CW-1:0];

  logic [PW-1:0] pre;
  logic          syncA;
  logic [CW-1:0] cnt;
  logic [CW-1:0] cntInc;
  logic [DIGITS-1:0] carry;

  // count-period prescaler
  always_ff @(posedge clk) begin
    if (!rstN) pre <= '0;
    else if (pre == PW'(DIV - 1)) pre <= '0;
    else pre <= pre + 1'b1;
  end
  assign tick = (pre == PW'(DIV - 1));

  // two-flop synchroniser for the comparator
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA   <= 1'b0;
      cmpSync <= 1'b0;
    end else begin
      syncA   <= cmpIn;
      cmpSync <= syncA;
    end
  end

  // decimal increment, one digit per generate slice
  assign carry[0] = 1'b1;
  genvar d;
  generate
    for (d = 0; d < DIGITS; d++) begin : gDigit
      logic [3:0] dig;
      assign dig = cnt[4*d +: 4];
      assign cntInc[4*d +: 4] = !carry[d] ? dig :
                                (dig == 4'd9) ? 4'd0 : dig + 4'd1;
      if (d < DIGITS - 1) begin : gCarry
        assign carry[d+1] = carry[d] && (dig == 4'd9);
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) cnt <= '0;
    else if (tick) cnt <= cmd.clrCnt ? '0 : cntInc;
  end

  assign atSigEnd    = (cntInc == SIG_B);
  assign atRefMax    = (cntInc == REF_B);
  assign atWindowEnd = (cntInc == WIN_B);

  // sign held from the close of signal integration
  always_ff @(posedge clk) begin
    if (!rstN) polCmp <= 1'b0;
    else if (cmd.latchPol) polCmp <= cmpSync;
  end

  // result capture
  always_ff @(posedge clk) begin
    if (!rstN) begin
      readingBcd  <= '0;
      readingNeg  <= 1'b0;
      overRange   <= 1'b0;
      latchStrobe <= 1'b0;
    end else begin
      latchStrobe <= cmd.capture;
      if (cmd.capture) begin
        readingBcd <= cntInc;
        readingNeg <= !polCmp;
        overRange  <= atRefMax;
      end
    end
  end

endmodule

// File: rtl/dsl_ctrl.sv
module dsl_ctrl
  import dsl_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    tick,
  input  logic    cmpSync,
  input  logic    polCmp,
  input  logic    atSigEnd,
  input  logic    atRefMax,
  input  logic    atWindowEnd,
  output phase_t  phase,
  output seqCmd_t cmd
);

  phase_t nxt;
  logic   crossed;

  assign crossed = cmpSync ^ polCmp;

  always_comb begin
    nxt = phase;
    cmd = '0;
    if (tick) begin
      case (phase)
        PH_AZ: if (atWindowEnd) begin
          nxt        = PH_SIG;
          cmd.clrCnt = 1'b1;
        end
        PH_SIG: if (atSigEnd) begin
          nxt          = PH_REF;
          cmd.clrCnt   = 1'b1;
          cmd.latchPol = 1'b1;
        end
        PH_REF: if (crossed || atRefMax) begin
          nxt         = PH_AZ;
          cmd.capture = 1'b1;
        end
        default: nxt = PH_AZ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) phase <= PH_AZ;
    else phase <= nxt;
  end

endmodule

// File: rtl/dsl_sequencer.sv
module dsl_sequencer
  import dsl_pkg::*;
#(
  parameter int DIV        = 4,
  parameter int DIGITS     = 4,
  parameter int SIG_COUNTS = 1000,
  parameter int REF_MAX    = 2000,
  parameter int AZ_MIN     = 1000
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cmpIn,
  output logic                azOn,
  output logic                sigOn,
  output logic                refDown,
  output logic                refUp,
  output logic [4*DIGITS-1:0] readingBcd,
  output logic                readingNeg,
  output logic                overRange,
  output logic                latchStrobe
);

  phase_t  phase;
  seqCmd_t cmd;
  logic    tick, cmpSync, polCmp;
  logic    atSigEnd, atRefMax, atWindowEnd;

  dsl_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .tick(tick), .cmpSync(cmpSync), .polCmp(polCmp),
    .atSigEnd(atSigEnd), .atRefMax(atRefMax), .atWindowEnd(atWindowEnd),
    .phase(phase), .cmd(cmd)
  );

  dsl_datapath #(
    .DIV(DIV), .DIGITS(DIGITS), .SIG_COUNTS(SIG_COUNTS),
    .REF_MAX(REF_MAX), .AZ_MIN(AZ_MIN)
  ) dp_i (
    .clk(clk), .rstN(rstN), .cmpIn(cmpIn), .cmd(cmd), .tick(tick),
    .cmpSync(cmpSync), .polCmp(polCmp), .atSigEnd(atSigEnd),
    .atRefMax(atRefMax), .atWindowEnd(atWindowEnd),
    .readingBcd(readingBcd), .readingNeg(readingNeg),
    .overRange(overRange), .latchStrobe(latchStrobe)
  );

  assign azOn    = (phase == PH_AZ);
  assign sigOn   = (phase == PH_SIG);
  assign refDown = (phase == PH_REF) && polCmp;
  assign refUp   = (phase == PH_REF) && !polCmp;

endmodule

// File: rtl/dsl_sequencer_chk.sv
module dsl_sequencer_chk
  import dsl_pkg::*;
#(
  parameter int DIGITS  = 4,
  parameter int REF_MAX = 2000
) (
  input logic                clk,
  input logic                rstN,
  input logic                azOn,
  input logic                sigOn,
  input logic                refDown,
  input logic                refUp,
  input logic [4*DIGITS-1:0] readingBcd,
  input logic                overRange,
  input logic                latchStrobe
);

  localparam logic [31:0] MAX_B32 = toBcd(REF_MAX);
  localparam logic [4*DIGITS-1:0] MAX_B = MAX_B32[4*DIGITS-1:0];

  function automatic logic digitsOk(input logic [4*DIGITS-1:0] v);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < DIGITS; i++) if (v[4*i +: 4] > 4'd9) ok = 1'b0;
    return ok;
  endfunction

  assert_onehot_switch_R8: assert property (@(posedge clk) disable iff (!rstN)
    $countones({azOn, sigOn, refDown, refUp}) == 1);

  assert_sig_after_az_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sigOn) |-> $past(azOn));

  assert_ref_after_sig_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(refDown || refUp) |-> $past(sigOn));

  assert_strobe_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    latchStrobe |=> !latchStrobe);

  assert_strobe_at_ref_exit_R7: assert property (@(posedge clk) disable iff (!rstN)
    latchStrobe |-> (azOn && $past(refDown || refUp)));

  assert_reading_held_R7: assert property (@(posedge clk) disable iff (!rstN)
    !latchStrobe |-> $stable(readingBcd));

  assert_overrange_value_R5: assert property (@(posedge clk) disable iff (!rstN)
    overRange |-> (readingBcd == MAX_B));

  assert_bcd_digits_R3: assert property (@(posedge clk) disable iff (!rstN)
    digitsOk(readingBcd));

endmodule

bind dsl_sequencer dsl_sequencer_chk #(.DIGITS(DIGITS), .REF_MAX(REF_MAX)) chk_i (
  .clk(clk), .rstN(rstN), .azOn(azOn), .sigOn(sigOn), .refDown(refDown),
  .refUp(refUp), .readingBcd(readingBcd), .overRange(overRange),
  .latchStrobe(latchStrobe)
);

// File: tb/dsl_sequencer_tb_top.sv
`timescale 1ns/1ps
module dsl_sequencer_tb_top;

  typedef struct packed {
    logic [15:0] reading;
    logic        neg;
    logic        ovr;
    int          dueCyc;
  } expItem_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmpIn = 1'b0;
  logic azOn, sigOn, refDown, refUp, readingNeg, overRange, latchStrobe;
  logic [15:0] readingBcd;

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  int oneHotBad = 0;
  bit done = 1'b0;
  expItem_t expQ[$];

  always #10 clk = ~clk;

  dsl_sequencer dut_i (
    .clk(clk), .rstN(rstN), .cmpIn(cmpIn), .azOn(azOn), .sigOn(sigOn),
    .refDown(refDown), .refUp(refUp), .readingBcd(readingBcd),
    .readingNeg(readingNeg), .overRange(overRange), .latchStrobe(latchStrobe)
  );

  always @(posedge clk) begin
    if (!rstN) cyc <= 0;
    else cyc <= cyc + 1;
  end

  function automatic logic [15:0] bcdOf(input int v);
    logic [15:0] r;
    int t;
    t = v;
    for (int i = 0; i < 4; i++) begin
      r[4*i +: 4] = 4'(t % 10);
      t = t / 10;
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at cyc %0d", req, act, exp, cyc);
    end
  endtask

  // driver: one measurement; k=0 means never flip (overrange)
  task automatic runMeasure(input logic sign, input int k, input bit late);
    expItem_t it;
    int t0;
    int eff;
    do @(negedge clk); while (!sigOn);
    cmpIn = sign;
    do @(negedge clk); while (!(refDown || refUp));
    t0 = cyc;
    check(refDown == sign && refUp == !sign, "R4", {refDown, refUp}, {sign, !sign});
    if (k == 0) begin
      it = '{reading: 16'h2000, neg: !sign, ovr: 1'b1, dueCyc: t0 + 8000};
      expQ.push_back(it);
    end else begin
      eff = late ? k + 1 : k;
      it = '{reading: bcdOf(eff), neg: !sign, ovr: (eff >= 2000), dueCyc: t0 + 4*eff};
      expQ.push_back(it);
      repeat (4*k - 3 + (late ? 1 : 0)) @(negedge clk);
      cmpIn = ~sign;
    end
  endtask

  // monitor: scoreboard, hold check, phase timing, one-hot
  int sigLen = 0;
  int lastRise = -1;
  logic prevSig = 1'b0;
  bit holdPending = 1'b0;
  logic [15:0] heldReading;

  always @(negedge clk) begin
    if (rstN) begin
      if ($countones({azOn, sigOn, refDown, refUp}) != 1) oneHotBad++;
      if (holdPending) begin
        holdPending = 1'b0;
        check(!latchStrobe && azOn && readingBcd == heldReading, "R7",
              readingBcd, heldReading);
      end
      if (latchStrobe) begin
        if (expQ.size() == 0) check(1'b0, "R7 unexpected strobe", 1, 0);
        else begin
          expItem_t e;
          e = expQ.pop_front();
          check(readingBcd == e.reading, e.ovr ? "R5 reading" : "R3 reading",
                readingBcd, e.reading);
          check(readingNeg == e.neg, "R4 sign", readingNeg, e.neg);
          check(overRange == e.ovr, "R5 overrange", overRange, e.ovr);
          check(cyc == e.dueCyc, "R9 strobe timing", cyc, e.dueCyc);
          holdPending = 1'b1;
          heldReading = readingBcd;
        end
      end
      if (sigOn && !prevSig) begin
        if (lastRise < 0) check(cyc == 12000, "R2 first zeroing", cyc, 12000);
        else check(cyc - lastRise == 16000, "R6 period", cyc - lastRise, 16000);
        lastRise = cyc;
      end
      if (sigOn) sigLen++;
      else if (prevSig) begin
        check(sigLen == 4000, "R1 integrate length", sigLen, 4000);
        sigLen = 0;
      end
      prevSig = sigOn;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(azOn && !sigOn && !refDown && !refUp, "R10 switches",
          {azOn, sigOn, refDown, refUp}, 4'b1000);
    check(readingBcd == 16'h0 && !readingNeg && !overRange && !latchStrobe,
          "R10 results", {readingBcd, readingNeg, overRange, latchStrobe}, 0);
    rstN = 1'b1;
    runMeasure(1'b1, 1000, 1'b0);  // R3 mid-scale positive
    runMeasure(1'b0, 1000, 1'b0);  // R4 negative
    runMeasure(1'b1, 1999, 1'b0);  // R3 full scale
    runMeasure(1'b0, 1,    1'b0);  // R3 smallest count
    runMeasure(1'b1, 5,    1'b1);  // R9 late flip seen one count later
    runMeasure(1'b1, 0,    1'b0);  // R5 overrange positive
    runMeasure(1'b0, 1234, 1'b0);  // R3 mixed digits
    runMeasure(1'b0, 0,    1'b0);  // R5 overrange negative
    while (expQ.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    check(oneHotBad == 0, "R8 one-hot", oneHotBad, 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=<190000 cycles", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule